// File: doc/BRIEF.md
# Data-Processing Second Operand Shifter

This purely combinational block builds the second source operand of a 32-bit RISC data-processing instruction, together with the carry produced by the shifter. It accepts the operand fields of the instruction, the values already read for the shifted register and the amount register, and the current carry flag. The block has no clock and no state.

There are three operand forms. The first is a small constant: an 8-bit value, zero-extended to 32 bits and rotated right by an even number of places. The second is a register shifted by a 5-bit amount held in the instruction. The third is a register shifted by an amount taken from the low byte of another register. A 2-bit code selects one of four shift kinds.

The corner cases follow the usual conventions of this instruction class. In the field form, a zero amount encodes a shift of 32 or a rotate through the carry. In the register form, amounts above 31 saturate or wrap depending on the shift kind.

Top module: `dp_operand_shifter`

## Requirements
- R1: When `use_imm` is 1, `operand` equals `imm8` zero-extended to 32 bits and rotated right by 2×`rot` places (for example, `imm8`=0x0F with `rot`=3 gives 0x3C000000).
- R2: When `use_imm` is 1, `carry_out` equals `carry_in` if `rot` is 0, and equals bit 31 of `operand` otherwise.
- R3: `sh_kind` codes are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. For any nonzero effective shift, `carry_out` is the last bit moved out of `rm_val`.
- R4: With `use_imm`=0 and `amt_from_reg`=0, `rm_val` is shifted by `shamt`. A `shamt` of 0 with logical left returns `rm_val` unchanged, with `carry_out` = `carry_in`.
- R5: In the field form, `shamt`=0 with logical right or arithmetic right acts as a shift by 32. Logical right gives 0, arithmetic right gives 32 copies of `rm_val[31]`, and both give `carry_out` = `rm_val[31]`.
- R6: In the field form, `shamt`=0 with rotate right gives `{carry_in, rm_val[31:1]}`, with `carry_out` = `rm_val[0]`.
- R7: With `use_imm`=0 and `amt_from_reg`=1, only `rs_val[7:0]` sets the amount, and bits 31:8 have no effect. An amount of 0 returns `rm_val` with `carry_out` = `carry_in`, for every shift kind.
- R8: In the register form, a logical shift by exactly 32 gives 0, with `carry_out` = `rm_val[0]` for left and `rm_val[31]` for right. A logical shift by more than 32 gives 0 with `carry_out` = 0.
- R9: In the register form, an arithmetic right shift by 32 or more fills every bit with `rm_val[31]`, with `carry_out` = `rm_val[31]`.
- R10: In the register form, rotate right uses the amount modulo 32. A nonzero multiple of 32 returns `rm_val` unchanged with `carry_out` = `rm_val[31]`.
- R11: `use_imm`=1 selects the constant form whatever the values of `amt_from_reg`, `shamt`, `sh_kind`, `rm_val` and `rs_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | Selects the rotated-constant form |
| amt_from_reg | input | 1 | Register form: amount from `rs_val` instead of `shamt` |
| imm8 | input | 8 | Constant field |
| rot | input | 4 | Constant rotate field (rotate by twice this value) |
| shamt | input | 5 | Shift amount field |
| sh_kind | input | 2 | Shift kind code |
| rm_val | input | 32 | Value of the register being shifted |
| rs_val | input | 32 | Value of the register that supplies the amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The checker evaluates its properties whenever the inputs settle. It assumes that all inputs change together, and that none of them is X or Z. The bench meets both conditions: it sets every input from a single task before each delay, and it draws every value from defined constant patterns. Fields that a form does not use are still driven to varying values, so that any leak of them into the result shows up.

// File: rtl/dp_operand_shifter.sv
`timescale 1ns/1ps
module dp_operand_shifter #(
  parameter int DW = 32
) (
  input  logic          use_imm,
  input  logic          amt_from_reg,
  input  logic [7:0]    imm8,
  input  logic [3:0]    rot,
  input  logic [4:0]    shamt,
  input  logic [1:0]    sh_kind,
  input  logic [DW-1:0] rm_val,
  input  logic [DW-1:0] rs_val,
  input  logic          carry_in,
  output logic [DW-1:0] operand,
  output logic          carry_out
);
  localparam int AW = $clog2(DW);
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;
  localparam logic [1:0] K_ROR = 2'b11;

  logic [7:0]    amt;
  logic          rrx;
  logic [DW:0]   lsl_w, lsr_w, asr_w;
  logic [DW-1:0] ror_v, imm_ext, imm_v;
  logic [AW-1:0] imm_amt;
  logic          unused_rs_hi;

  assign unused_rs_hi = |rs_val[DW-1:8];

  always_comb begin
    rrx = 1'b0;
    amt = amt_from_reg ? rs_val[7:0] : {3'b000, shamt};
    if (!amt_from_reg && shamt == 5'd0) begin
      if (sh_kind == K_LSR || sh_kind == K_ASR) amt = 8'(DW);
      else if (sh_kind == K_ROR)                rrx = 1'b1;
    end
  end

  assign lsl_w = {1'b0, rm_val} << amt;
  assign lsr_w = {rm_val, 1'b0} >> amt;
  assign asr_w = $signed({rm_val, 1'b0}) >>> amt;
  assign ror_v = (rm_val >> amt[AW-1:0]) | (rm_val << (DW - int'(amt[AW-1:0])));

  assign imm_ext = {{(DW-8){1'b0}}, imm8};
  assign imm_amt = {rot, 1'b0};
  assign imm_v   = (imm_ext >> imm_amt) | (imm_ext << (DW - int'(imm_amt)));

  always_comb begin
    if (use_imm) begin
      operand   = imm_v;
      carry_out = (rot == 4'd0) ? carry_in : imm_v[DW-1];
    end else if (rrx) begin
      operand   = {carry_in, rm_val[DW-1:1]};
      carry_out = rm_val[0];
    end else if (amt == 8'd0) begin
      operand   = rm_val;
      carry_out = carry_in;
    end else begin
      case (sh_kind)
        K_LSL:   begin operand = lsl_w[DW-1:0]; carry_out = lsl_w[DW]; end
        K_LSR:   begin operand = lsr_w[DW:1];   carry_out = lsr_w[0];  end
        K_ASR:   begin operand = asr_w[DW:1];   carry_out = asr_w[0];  end
        default: begin operand = ror_v;         carry_out = ror_v[DW-1]; end
      endcase
    end
  end
endmodule

module dp_operand_shifter_chk #(
  parameter int DW = 32
) (
  input logic          use_imm,
  input logic          amt_from_reg,
  input logic [7:0]    imm8,
  input logic [3:0]    rot,
  input logic [4:0]    shamt,
  input logic [1:0]    sh_kind,
  input logic [DW-1:0] rm_val,
  input logic [DW-1:0] rs_val,
  input logic          carry_in,
  input logic [DW-1:0] operand,
  input logic          carry_out
);
  logic reg_form, fld_form;
  assign reg_form = !use_imm && amt_from_reg;
  assign fld_form = !use_imm && !amt_from_reg;

  always_comb begin
    if (use_imm && rot == 4'd0)
      assert_imm_norot_R1: assert (operand == {{(DW-8){1'b0}}, imm8})
        else $error("constant without rotate altered");
    if (use_imm)
      assert_imm_bits_R1: assert ($countones(operand) == $countones(imm8))
        else $error("constant rotate changed bit count");
    if (use_imm)
      assert_imm_carry_R2: assert (carry_out == ((rot == 4'd0) ? carry_in : operand[DW-1]))
        else $error("constant carry wrong");
    if (reg_form && rs_val[7:0] == 8'd0)
      assert_reg_zero_R7: assert (operand == rm_val && carry_out == carry_in)
        else $error("zero register amount not a pass-through");
    if (reg_form && sh_kind[1] == 1'b0 && rs_val[7:0] > 8'(DW))
      assert_reg_logic_big_R8: assert (operand == '0 && !carry_out)
        else $error("long logical shift not cleared");
    if (reg_form && sh_kind == 2'b10 && rs_val[7:0] >= 8'(DW))
      assert_reg_asr_big_R9: assert (operand == {DW{rm_val[DW-1]}} && carry_out == rm_val[DW-1])
        else $error("long arithmetic shift not sign filled");
    if (fld_form && shamt == 5'd0 && sh_kind == 2'b11)
      assert_rrx_R6: assert (operand[DW-1] == carry_in && carry_out == rm_val[0])
        else $error("rotate through carry wrong");
    if (reg_form && sh_kind == 2'b11)
      assert_reg_ror_bits_R10: assert ($countones(operand) == $countones(rm_val))
        else $error("rotate changed bit count");
  end
endmodule

bind dp_operand_shifter dp_operand_shifter_chk #(.DW(DW)) u_chk (
  .use_imm(use_imm), .amt_from_reg(amt_from_reg), .imm8(imm8), .rot(rot),
  .shamt(shamt), .sh_kind(sh_kind), .rm_val(rm_val), .rs_val(rs_val),
  .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
);

// File: tb/dp_operand_shifter_test.sv
`timescale 1ns/1ps
module dp_operand_shifter_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        use_imm, amt_from_reg, carry_in, carry_out;
  logic [7:0]  imm8;
  logic [3:0]  rot;
  logic [4:0]  shamt;
  logic [1:0]  sh_kind;
  logic [31:0] rm_val, rs_val, operand;

  dp_operand_shifter uut (
    .use_imm(use_imm), .amt_from_reg(amt_from_reg), .imm8(imm8), .rot(rot),
    .shamt(shamt), .sh_kind(sh_kind), .rm_val(rm_val), .rs_val(rs_val),
    .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] pats [8] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE,
                            32'h1234_5678, 32'hA5A5_A5A5, 32'hDEAD_BEEF, 32'h0000_0001};

  // bit-at-a-time model of a shift kind; returns {carry, value}
  function automatic logic [32:0] step_model(input logic [31:0] v, input logic [1:0] k,
                                             input int n, input logic c);
    logic [31:0] r;
    logic cc;
    r = v; cc = c;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00:   begin cc = r[31]; r = {r[30:0], 1'b0}; end
        2'b01:   begin cc = r[0];  r = {1'b0, r[31:1]}; end
        2'b10:   begin cc = r[0];  r = {r[31], r[31:1]}; end
        default: begin cc = r[0];  r = {r[0], r[31:1]}; end
      endcase
    end
    return {cc, r};
  endfunction

  task automatic apply(input logic ui, input logic ar, input logic [7:0] i8, input logic [3:0] ro,
                       input logic [4:0] sa, input logic [1:0] k, input logic [31:0] rm,
                       input logic [31:0] rs, input logic ci);
    use_imm = ui; amt_from_reg = ar; imm8 = i8; rot = ro; shamt = sa;
    sh_kind = k; rm_val = rm; rs_val = rs; carry_in = ci;
    #1;
  endtask

  task automatic check(input string tag, input logic [32:0] exp);
    checks++;
    if ({carry_out, operand} !== exp) begin
      failures++;
      $display("FAIL %s: got carry=%0b operand=%08h expected carry=%0b operand=%08h",
               tag, carry_out, operand, exp[32], exp[31:0]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [32:0] e;
    // all-zero inputs (idle state of a combinational block)
    apply(0, 0, 8'h00, 4'h0, 5'd0, 2'b00, 32'h0, 32'h0, 1'b1);
    check("R4 idle", {1'b1, 32'h0});

    // R1: worked example
    apply(1, 0, 8'h0F, 4'd3, 5'd0, 2'b00, 32'h0, 32'h0, 1'b0);
    check("R1 example", {1'b0, 32'h3C00_0000});

    // R1 / R2 / R11: exhaustive constant sweep, other fields scrambled
    for (int i = 0; i < 256; i++)
      for (int r = 0; r < 16; r++) begin
        logic ci;
        ci = i[0] ^ r[0];
        apply(1, i[1], 8'(i), 4'(r), 5'(i * 7), 2'(r), pats[i % 8], pats[r % 8], ci);
        e = step_model({24'h0, 8'(i)}, 2'b11, 2 * r, 1'b0);
        e[32] = (r == 0) ? ci : e[31];
        check(i[1] ? "R11 constant with register fields" : "R1 R2 constant", e);
      end

    // field form sweep: R3 R4 R5 R6
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 32; s++)
        for (int p = 0; p < 8; p++)
          for (int c = 0; c < 2; c++) begin
            apply(0, 0, 8'(s * 3), 4'(p), 5'(s), 2'(k), pats[p], pats[7 - p], c[0]);
            if (s == 0 && k == 3) begin
              e = {pats[p][0], c[0], pats[p][31:1]};
              check("R6 rotate through carry", e);
            end else if (s == 0 && (k == 1 || k == 2)) begin
              e = step_model(pats[p], 2'(k), 32, c[0]);
              check("R5 zero field means 32", e);
            end else begin
              e = step_model(pats[p], 2'(k), s, c[0]);
              check(s == 0 ? "R4 zero left shift" : "R3 R4 field shift", e);
            end
          end

    // register form sweep: R7 R8 R9 R10
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 48; a++)
        for (int p = 0; p < 8; p++)
          for (int c = 0; c < 2; c++) begin
            int amt;
            logic [31:0] rs;
            amt = (a < 40) ? a : (a == 40 ? 63 : a == 41 ? 64 : a == 42 ? 65 :
                  a == 43 ? 96 : a == 44 ? 127 : a == 45 ? 128 : a == 46 ? 200 : 255);
            rs = {pats[(p + a) % 8][31:8], 8'(amt)};
            apply(0, 1, 8'(a), 4'(p), 5'(a + 1), 2'(k), pats[p], rs, c[0]);
            e = step_model(pats[p], 2'(k), amt, c[0]);
            if (amt == 0)        check("R7 zero register amount", e);
            else if (k == 3)     check("R10 register rotate", e);
            else if (k == 2)     check("R9 register arithmetic", e);
            else if (amt >= 32)  check("R8 long logical", e);
            else                 check("R3 register shift", e);
          end

    // R8 explicit boundary values
    apply(0, 1, 8'h0, 4'h0, 5'd0, 2'b00, 32'h0000_0001, 32'hFFFF_FF20, 1'b0);
    check("R8 left by 32", {1'b1, 32'h0});
    apply(0, 1, 8'h0, 4'h0, 5'd0, 2'b01, 32'h8000_0000, 32'h0000_0021, 1'b1);
    check("R8 right by 33", {1'b0, 32'h0});
    // R10 multiple of 32
    apply(0, 1, 8'h0, 4'h0, 5'd0, 2'b11, 32'h8000_1234, 32'h0000_0040, 1'b0);
    check("R10 rotate by 64", {1'b1, 32'h8000_1234});
    // R7 upper bits ignored
    apply(0, 1, 8'h0, 4'h0, 5'd0, 2'b01, 32'hF000_000F, 32'hFFFF_FF00, 1'b0);
    check("R7 upper amount bits ignored", {1'b0, 32'hF000_000F});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule